// File: doc/BRIEF.md
# Power-of-Two Clock Enable Generator

This block turns one free-running system clock into two single-cycle enable strobes at rates that are harmonics of each other. The slower strobe runs at a base rate and the faster one at twice that rate. Downstream logic keeps running on the system clock and qualifies its registers with the strobes. No derived clock is created, so the whole design stays in a single clock domain.

The block has two parameters: the system clock frequency and the requested base rate. Their quotient is the nominal divide ratio. The counter is `W = ceil(log2(ratio))` bits wide, so the real period is `2^W` system cycles. The base rate is therefore the request rounded down to the nearest rate a power of two can give. With the defaults (1000 and 100), the ratio is 10, `W` is 4 and the period is 16 cycles.

The two square waves that the enables are derived from are also brought out, for logic that wants a level rather than a strobe.

Top module: `pow2_ce_gen`

## Requirements
- R1: Let k be the number of rising clock edges, with `rstN` high, since `rstN` was last sampled low, and let m = k mod 2^W. `sqBase` is high exactly when m >= 2^(W-1). This is the counter's top bit.
- R2: `sqDouble` is high exactly when floor(m / 2^(W-2)) is even. This is the inverse of the counter's second-highest bit.
- R3: `rstN` is active low and sampled on the clock edge, and it overrides counting. While it is held low, the outputs read `sqBase`=0, `sqDouble`=1, `ceBase`=0 and `ceDouble`=0. Counting restarts from k=0 once it is released.
- R4: `ceBase` is high for exactly one cycle, when m = 2^(W-1). That is the cycle in which `sqBase` has just gone from 0 to 1.
- R5: `ceDouble` is high for exactly one cycle when k > 0 and m mod 2^(W-1) = 0. That is the cycle in which `sqDouble` has just gone from 0 to 1.
- R6: No enable is produced while reset is held, or in the first cycle after it is released, even though `sqDouble` is already high then.
- R7: In every run of 2^W cycles after release, `ceBase` pulses once and `ceDouble` pulses twice. Consecutive `ceDouble` pulses are 2^(W-1) cycles apart, and every `ceBase` pulse coincides with a `ceDouble` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| ceBase | output | 1 | One-cycle enable at the base rate |
| ceDouble | output | 1 | One-cycle enable at twice the base rate |
| sqBase | output | 1 | Square wave at the base rate (counter top bit) |
| sqDouble | output | 1 | Square wave at double rate (inverted second bit) |

## Verification
The bench pays most attention to the cycle right after reset is released. At that point `sqDouble` is already high while the edge history is clear. A design that did not hold off detection there would emit a spurious `ceDouble` while still in reset. The bench also pulses reset in the middle of a period. A design whose reset lost priority to the increment, or failed to clear the edge history, would then put its next strobes at the wrong offsets. Finally, the bench runs long enough to cover the counter wrapping from all ones to zero, where `ceDouble` must fire but `ceBase` must not. It checks the spacing between `ceDouble` pulses across that wrap, which exposes a detector set to the wrong polarity or the wrong bit.

// File: rtl/cegen_pkg.sv
package cegen_pkg;

  // square-wave taps the datapath hands to the control
  typedef struct packed {
    logic base;
    logic dbl;
  } tapT;

  // enable strobes produced by the control
  typedef struct packed {
    logic ceBase;
    logic ceDouble;
  } strobeT;

  // counter width: ceiling of log2 of the nominal divide ratio
  function automatic int calcWidth(input int clkHz, input int baseHz);
    return $clog2(clkHz / baseHz);
  endfunction

endpackage

// File: rtl/ce_count_path.sv
module ce_count_path
  import cegen_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rstN,
  output tapT  taps
);

  logic [WIDTH-1:0] cnt;

  // reset wins over the increment
  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  assign taps.base = cnt[WIDTH-1];
  assign taps.dbl  = ~cnt[WIDTH-2];

  // R1: counter advances by one on every released edge
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> cnt == $past(cnt) + 1'b1);

  // R3: the first cycle after release starts from zero
  p_reset_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> cnt == '0);

endmodule

// File: rtl/ce_edge_ctrl.sv
module ce_edge_ctrl
  import cegen_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  tapT    taps,
  output strobeT strobes
);

  localparam int NTAP = 2;

  logic [NTAP-1:0] cur;
  logic [NTAP-1:0] prev;
  logic [NTAP-1:0] rise;
  logic            armed;

  assign cur = {taps.base, taps.dbl};

  // edge history and an arm flag that blocks the first post-reset cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prev  <= '0;
      armed <= 1'b0;
    end else begin
      prev  <= cur;
      armed <= 1'b1;
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_rise
    assign rise[t] = armed & cur[t] & ~prev[t];
  end

  assign strobes.ceBase   = rise[1];
  assign strobes.ceDouble = rise[0];

  // R4: base enable lasts a single cycle
  p_base_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ceBase |=> !strobes.ceBase);

  // R5: double enable lasts a single cycle
  p_dbl_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ceDouble |=> !strobes.ceDouble);

  // R6: nothing fires in the cycle right after release
  p_no_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !strobes.ceBase && !strobes.ceDouble);

  // R7: every base pulse lines up with a double pulse
  p_base_in_dbl_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ceBase |-> strobes.ceDouble);

endmodule

// File: rtl/pow2_ce_gen.sv
module pow2_ce_gen
  import cegen_pkg::*;
#(
  parameter int CLK_HZ  = 1000,
  parameter int BASE_HZ = 100
) (
  input  logic clk,
  input  logic rstN,
  output logic ceBase,
  output logic ceDouble,
  output logic sqBase,
  output logic sqDouble
);

  localparam int WIDTH = calcWidth(CLK_HZ, BASE_HZ);

  if (WIDTH < 2) begin : g_bad_width
    $error("pow2_ce_gen: counter width must be at least 2");
  end

  tapT    taps;
  strobeT strobes;

  ce_count_path #(.WIDTH(WIDTH)) i_path (
    .clk  (clk),
    .rstN (rstN),
    .taps (taps)
  );

  ce_edge_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .taps    (taps),
    .strobes (strobes)
  );

  assign ceBase   = strobes.ceBase;
  assign ceDouble = strobes.ceDouble;
  assign sqBase   = taps.base;
  assign sqDouble = taps.dbl;

endmodule

// File: tb/test_pow2_ce_gen.sv
`timescale 1ns/1ps
module test_pow2_ce_gen;

  localparam int CLK_HZ  = 1000;
  localparam int BASE_HZ = 100;
  localparam int W    = $clog2(CLK_HZ / BASE_HZ);
  localparam int P    = 1 << W;
  localparam int HALF = P / 2;
  localparam int QTR  = P / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceBase, ceDouble, sqBase, sqDouble;

  always #2.5 clk = ~clk;

  pow2_ce_gen #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ)) i_pow2_ce_gen (
    .clk(clk), .rstN(rstN), .ceBase(ceBase), .ceDouble(ceDouble),
    .sqBase(sqBase), .sqDouble(sqDouble)
  );

  typedef struct {
    logic inReset;
    int   k;
    logic ceB, ceD, sqB, sqD;
  } expT;

  expT q[$];
  int checks = 0;
  int errors = 0;
  int k = 0;
  int lastDk = -1;
  int baseInWin = 0;
  int dblInWin = 0;

  task automatic chk(input string tag, input string what, input int kk,
                     input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s k=%0d actual=%0d expected=%0d", tag, what, kk, act, exp);
    end
  endtask

  // driver: sets reset for the next edge and queues the expected result
  task automatic stepCycle(input logic r);
    expT e;
    int m;
    @(negedge clk);
    rstN = r;
    if (!r) k = 0; else k = k + 1;
    m = k % P;
    e.inReset = !r;
    e.k = k;
    if (!r) begin
      e.ceB = 0; e.ceD = 0; e.sqB = 0; e.sqD = 1;
    end else begin
      e.sqB = (m >= HALF);
      e.sqD = (((m / QTR) % 2) == 0);
      e.ceB = (m == HALF);
      e.ceD = ((m % HALF) == 0);
    end
    q.push_back(e);
  endtask

  // monitor: pops one expectation per edge and compares
  always @(posedge clk) begin
    expT e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      if (e.inReset) begin
        chk("R3", "sqBase", e.k, sqBase, e.sqB);
        chk("R3", "sqDouble", e.k, sqDouble, e.sqD);
        chk("R6", "ceBase in reset", e.k, ceBase, 0);
        chk("R6", "ceDouble in reset", e.k, ceDouble, 0);
        lastDk = -1; baseInWin = 0; dblInWin = 0;
      end else begin
        chk("R1", "sqBase", e.k, sqBase, e.sqB);
        chk("R2", "sqDouble", e.k, sqDouble, e.sqD);
        chk("R4", "ceBase", e.k, ceBase, e.ceB);
        chk("R5", "ceDouble", e.k, ceDouble, e.ceD);
        if (e.k == 1) chk("R6", "ceDouble first cycle", e.k, ceDouble, 0);
        if (ceDouble === 1'b1) begin
          if (lastDk >= 0) chk("R7", "ceDouble spacing", e.k, e.k - lastDk, HALF);
          lastDk = e.k;
          dblInWin++;
        end
        if (ceBase === 1'b1) baseInWin++;
        if (e.k % P == 0) begin
          chk("R7", "ceBase per window", e.k, baseInWin, 1);
          chk("R7", "ceDouble per window", e.k, dblInWin, 2);
          baseInWin = 0; dblInWin = 0;
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) stepCycle(1'b0);
    for (int i = 0; i < 5 * P + 3; i++) stepCycle(1'b1);
    for (int i = 0; i < 2; i++) stepCycle(1'b0);   // reset mid-period
    for (int i = 0; i < 3 * P + 5; i++) stepCycle(1'b1);
    stepCycle(1'b0);                                // one-cycle reset
    for (int i = 0; i < 12 * P; i++) stepCycle(1'b1);
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule